// File: doc/BRIEF.md
# Iterative Double-Width Integer Divider

This block divides a dividend of twice the operand width by a single-width divisor and returns a single-width quotient and remainder. The dividend arrives as two words, a high half and a low half. The divisor and both results are one word. A two-bit size code selects an operand width of 8, 16, 32 or 64 bits at run time. Bits of the input words above the selected width are ignored, and the result words read zero above it.

The datapath is a restoring shift-subtract engine. The high dividend word is checked against the divisor before any bit iteration starts. After that, each clock cycle retires several quotient bits: two for the byte size and four for the wider sizes. Signed division wraps the same unsigned engine. On entry it forms the magnitudes of the operands, negating the double-width dividend with a borrow carried from the low word into the high word. On exit it applies the signs: the remainder follows the dividend and the quotient is negated when the operand signs differ.

A request is raised with `start` while the block is idle. The block reports busy while it iterates and raises `done` for one cycle when the results and status flags are valid. Those outputs then hold until the next accepted request. A zero divisor and a quotient that cannot be represented are reported only through flags.

Top module: `signed_iter_divider`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `overflow`, `quotient` and `remainder` are all zero.
- R2: With `is_signed` low, the results equal the unsigned quotient and remainder of {hi,lo} divided by the divisor at the selected width (size code 0=8, 1=16, 2=32, 3=64 bits). The result bits above the width read zero.
- R3: With `is_signed` high, the operands are two's complement values whose sign is bit n-1 of the high word and bit n-1 of the divisor. The remainder takes the dividend's sign, and the quotient is negated when the two signs differ. Results are n-bit two's complement values with zeros above bit n-1.
- R4: A negative dividend is negated over the full 2n bits, so a borrow from the low word reaches the high word. This holds both when the low word is zero and when it is not.
- R5: For a request that iterates, `busy` is high from the cycle after the accepting edge, and `done` appears n/K+1 clock edges after that edge, with K=2 for 8-bit and K=4 otherwise. That is 5, 5, 9 and 17 cycles for the four sizes.
- R6: A divisor that is zero at the selected width sets `div_zero`, clears `overflow`, and raises `done` on the cycle right after the accepting edge without `busy`.
- R7: When the high dividend magnitude is greater than or equal to the divisor magnitude, `overflow` is set and `done` comes on the cycle right after the accepting edge. In unsigned mode this is the only overflow condition.
- R8: In signed mode, `overflow` is also set when the quotient magnitude exceeds 2^(n-1)-1 for a positive result or 2^(n-1) for a negative one. A quotient of exactly -2^(n-1) is not an overflow.
- R9: `start` is ignored while `busy` is high, and the running operation's results are unaffected. `done` lasts one cycle and never coincides with `busy`. Results and flags hold until the next accepted request.
- R10: Input bits above the selected width have no effect on any result or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; accepted only when not busy |
| is_signed | input | 1 | 1 selects two's complement operation |
| size_sel | input | 2 | Operand width code: 0=8, 1=16, 2=32, 3=64 bits |
| dividend_hi | input | XLEN | Upper half of the double-width dividend |
| dividend_lo | input | XLEN | Lower half of the double-width dividend |
| divisor | input | XLEN | Divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse: results and flags valid |
| quotient | output | XLEN | Quotient, zero above the selected width |
| remainder | output | XLEN | Remainder, zero above the selected width |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient not representable at the selected width |

## Verification
The bench compares each result with a 128-bit reference computed from the requirements. It targets the following cases:
- Negative dividends with both a zero and a nonzero low word. A design that drops the borrow returns a quotient off by a whole high-word unit.
- Mixed-sign pairs. A sign fix-up keyed to the wrong operand gives a remainder or quotient with the wrong sign.
- The most negative quotient, which is valid, and its positive counterpart, which overflows. An off-by-one range check flags the first or misses the second.
- Garbage above the width, a start issued mid-operation, and the per-size cycle counts. These expose a missing mask, a restart that corrupts the running operation, and a wrong step count per cycle.

// File: rtl/sidiv_pkg.sv
`timescale 1ns/1ps
package sidiv_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } opsize_e;

  // operand width in bits for a size code
  function automatic int unsigned size_bits(input logic [1:0] code);
    return 32'd8 << code;
  endfunction
endpackage

// File: rtl/sidiv_entry.sv
`timescale 1ns/1ps
// Operand conditioning: width masking, sign extraction and magnitudes.
module sidiv_entry import sidiv_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic            is_signed,
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] hi,
  input  logic [XLEN-1:0] lo,
  input  logic [XLEN-1:0] dv,
  output logic [XLEN-1:0] hi_mag,
  output logic [XLEN-1:0] lo_mag,
  output logic [XLEN-1:0] dv_mag,
  output logic [XLEN-1:0] mask,
  output logic            neg_dividend,
  output logic            neg_divisor
);
  localparam int CW = $clog2(XLEN) + 1;

  logic [CW-1:0]   nbits;
  logic [XLEN-1:0] sign_bit, hi_m, lo_m, dv_m, lo_neg, hi_neg, dv_neg;
  logic            borrow;

  assign nbits    = CW'(size_bits(size));
  assign mask     = ~({XLEN{1'b1}} << nbits);
  assign sign_bit = mask & ~(mask >> 1);

  assign hi_m = hi & mask;
  assign lo_m = lo & mask;
  assign dv_m = dv & mask;

  assign neg_dividend = is_signed & (|(hi_m & sign_bit));
  assign neg_divisor  = is_signed & (|(dv_m & sign_bit));

  // 2n-bit negate: low word first, its borrow then taken from the high word
  assign borrow = |lo_m;
  assign lo_neg = (~lo_m + 1'b1) & mask;
  assign hi_neg = (~hi_m + XLEN'(!borrow)) & mask;
  assign dv_neg = (~dv_m + 1'b1) & mask;

  assign hi_mag = neg_dividend ? hi_neg : hi_m;
  assign lo_mag = neg_dividend ? lo_neg : lo_m;
  assign dv_mag = neg_divisor  ? dv_neg : dv_m;
endmodule

// File: rtl/sidiv_core.sv
`timescale 1ns/1ps
// Unsigned restoring shift-subtract engine, several bit-steps per cycle.
module sidiv_core import sidiv_pkg::*; #(
  parameter int XLEN         = 64,
  parameter int STEPS_WIDE   = 4,
  parameter int STEPS_NARROW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] hi_mag,
  input  logic [XLEN-1:0] lo_mag,
  input  logic [XLEN-1:0] dv_mag,
  output logic [XLEN-1:0] q_mag,
  output logic [XLEN-1:0] r_mag,
  output logic            finish
);
  localparam int CW = $clog2(XLEN) + 1;

  logic [XLEN-1:0] rem_q, acc_q, dv_q;
  logic [CW-1:0]   cnt_q, nbits, step_ct;
  logic            narrow_q, active_q, last;

  logic [STEPS_WIDE:0][XLEN-1:0] st_rem;
  logic [STEPS_WIDE:0][XLEN-1:0] st_acc;

  assign nbits  = CW'(size_bits(size));
  assign st_rem[0] = rem_q;
  assign st_acc[0] = acc_q;

  generate
    for (genvar g = 0; g < STEPS_WIDE; g++) begin : g_step
      logic [XLEN:0]   shifted;
      logic [XLEN-1:0] diff;
      logic            fits;
      assign shifted = {st_rem[g], st_acc[g][XLEN-1]};
      assign fits    = shifted >= {1'b0, dv_q};
      assign diff    = shifted[XLEN-1:0] - dv_q;
      assign st_rem[g+1] = fits ? diff : shifted[XLEN-1:0];
      assign st_acc[g+1] = {st_acc[g][XLEN-2:0], fits};
    end
  endgenerate

  assign step_ct = narrow_q ? CW'(STEPS_NARROW) : CW'(STEPS_WIDE);
  assign last    = (cnt_q == step_ct);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q    <= '0;
      acc_q    <= '0;
      dv_q     <= '0;
      cnt_q    <= '0;
      narrow_q <= 1'b0;
      active_q <= 1'b0;
      finish   <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (load) begin
        rem_q    <= hi_mag;
        acc_q    <= lo_mag << (CW'(XLEN) - nbits);
        dv_q     <= dv_mag;
        cnt_q    <= nbits;
        narrow_q <= (opsize_e'(size) == SZ_BYTE);
        active_q <= 1'b1;
      end else if (active_q) begin
        rem_q <= narrow_q ? st_rem[STEPS_NARROW] : st_rem[STEPS_WIDE];
        acc_q <= narrow_q ? st_acc[STEPS_NARROW] : st_acc[STEPS_WIDE];
        cnt_q <= cnt_q - step_ct;
        if (last) begin
          active_q <= 1'b0;
          finish   <= 1'b1;
        end
      end
    end
  end

  assign q_mag = acc_q;
  assign r_mag = rem_q;

  // partial remainder never reaches the divisor (R2)
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (rem_q < dv_q));
  // bits remain while iterating (R5)
  assert_cnt_live_R5: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q != '0));
endmodule

// File: rtl/sidiv_exit.sv
`timescale 1ns/1ps
// Sign application and signed range check on the unsigned results.
module sidiv_exit #(
  parameter int XLEN = 64
) (
  input  logic            is_signed,
  input  logic            neg_dividend,
  input  logic            neg_divisor,
  input  logic [XLEN-1:0] mask,
  input  logic [XLEN-1:0] q_mag,
  input  logic [XLEN-1:0] r_mag,
  output logic [XLEN-1:0] q_out,
  output logic [XLEN-1:0] r_out,
  output logic            range_ovf
);
  logic            flip_q;
  logic [XLEN-1:0] pos_lim;

  assign flip_q  = is_signed & (neg_dividend ^ neg_divisor);
  assign pos_lim = mask >> 1;
  assign q_out   = flip_q ? ((~q_mag + 1'b1) & mask) : q_mag;
  assign r_out   = (is_signed & neg_dividend) ? ((~r_mag + 1'b1) & mask) : r_mag;
  assign range_ovf = is_signed &
                     (flip_q ? (q_mag > pos_lim + 1'b1) : (q_mag > pos_lim));
endmodule

// File: rtl/signed_iter_divider.sv
`timescale 1ns/1ps
module signed_iter_divider import sidiv_pkg::*; #(
  parameter int XLEN         = 64,
  parameter int STEPS_WIDE   = 4,
  parameter int STEPS_NARROW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            is_signed,
  input  logic [1:0]      size_sel,
  input  logic [XLEN-1:0] dividend_hi,
  input  logic [XLEN-1:0] dividend_lo,
  input  logic [XLEN-1:0] divisor,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] quotient,
  output logic [XLEN-1:0] remainder,
  output logic            div_zero,
  output logic            overflow
);
  logic [XLEN-1:0] hi_mag, lo_mag, dv_mag, mask;
  logic            sa, sb;
  logic            accept, early_dz, early_ov, core_load, core_finish;
  logic [XLEN-1:0] q_mag, r_mag, fix_q, fix_r;
  logic            fix_ov;
  logic            sgn_q, sa_q, sb_q;
  logic [XLEN-1:0] mask_q;

  sidiv_entry #(.XLEN(XLEN)) u_entry (
    .is_signed(is_signed), .size(size_sel),
    .hi(dividend_hi), .lo(dividend_lo), .dv(divisor),
    .hi_mag(hi_mag), .lo_mag(lo_mag), .dv_mag(dv_mag), .mask(mask),
    .neg_dividend(sa), .neg_divisor(sb)
  );

  assign accept    = start & ~busy;
  assign early_dz  = (dv_mag == '0);
  assign early_ov  = ~early_dz & (hi_mag >= dv_mag);
  assign core_load = accept & ~early_dz & ~early_ov;

  sidiv_core #(.XLEN(XLEN), .STEPS_WIDE(STEPS_WIDE), .STEPS_NARROW(STEPS_NARROW)) u_core (
    .clk(clk), .rst(rst), .load(core_load), .size(size_sel),
    .hi_mag(hi_mag), .lo_mag(lo_mag), .dv_mag(dv_mag),
    .q_mag(q_mag), .r_mag(r_mag), .finish(core_finish)
  );

  sidiv_exit #(.XLEN(XLEN)) u_exit (
    .is_signed(sgn_q), .neg_dividend(sa_q), .neg_divisor(sb_q), .mask(mask_q),
    .q_mag(q_mag), .r_mag(r_mag),
    .q_out(fix_q), .r_out(fix_r), .range_ovf(fix_ov)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
      overflow  <= 1'b0;
      sgn_q     <= 1'b0;
      sa_q      <= 1'b0;
      sb_q      <= 1'b0;
      mask_q    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        div_zero  <= early_dz;
        overflow  <= early_ov;
        quotient  <= '0;
        remainder <= '0;
        sgn_q     <= is_signed;
        sa_q      <= sa;
        sb_q      <= sb;
        mask_q    <= mask;
        if (early_dz || early_ov) done <= 1'b1;
        else                      busy <= 1'b1;
      end else if (core_finish) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        quotient  <= fix_q;
        remainder <= fix_r;
        overflow  <= fix_ov;
      end
    end
  end

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_done_cause_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(start) || $past(busy)));
  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(div_zero && overflow));
  assert_rem_sign_R3: assert property (@(posedge clk) disable iff (rst)
    (done && sgn_q && !overflow && !div_zero && (remainder != '0))
      |-> (((remainder & ~(mask_q >> 1)) != '0) == sa_q));
endmodule

// File: tb/sim_signed_iter_divider.sv
`timescale 1ns/1ps
module sim_signed_iter_divider;
  typedef struct packed {
    logic [1:0]  sz;
    logic        sg;
    logic [63:0] hi;
    logic [63:0] lo;
    logic [63:0] dv;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 64'h0, 64'h64, 64'h7},
    '{2'd0, 1'b0, 64'h12, 64'h34, 64'h56},
    '{2'd1, 1'b0, 64'h1, 64'h0, 64'h3},
    '{2'd2, 1'b0, 64'h1234, 64'h89AB_CDEF, 64'h1_0000},
    '{2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0FED_CBA9_8765_4321},
    '{2'd0, 1'b1, 64'hFF, 64'h9C, 64'h07},
    '{2'd0, 1'b1, 64'h00, 64'h64, 64'hF9},
    '{2'd1, 1'b1, 64'hFFFF, 64'h0000, 64'hFFFD},
    '{2'd2, 1'b1, 64'hFFFF_FFFF, 64'h8000_0001, 64'h3},
    '{2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h7},
    '{2'd3, 1'b1, 64'h0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'd0, 1'b1, 64'hFF, 64'h80, 64'h01},
    '{2'd0, 1'b0, 64'hAAAA_AAAA_AAAA_AA00, 64'h5555_5555_5555_55C8, 64'hFFFF_FFFF_FFFF_FF0A},
    '{2'd1, 1'b0, 64'hFFFE, 64'hFFFF, 64'hFFFF},
    '{2'd2, 1'b1, 64'hFFFF_FFFF, 64'h8000_0000, 64'hFFFF_FFFF},
    '{2'd0, 1'b0, 64'h10, 64'h5, 64'h10},
    '{2'd1, 1'b0, 64'h1234, 64'h5678, 64'hFFFF_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic [63:0] dividend_hi = '0, dividend_lo = '0, divisor = '0;
  logic        busy, done, div_zero, overflow;
  logic [63:0] quotient, remainder;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  signed_iter_divider u0 (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed), .size_sel(size_sel),
    .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_zero(div_zero), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements, 128-bit arithmetic
  function automatic void ref_div(input vec_t v, output logic [63:0] q, output logic [63:0] r,
                                  output logic ov, output logic dz, output logic early);
    int n;
    logic [127:0] m1, m2, hm, lm, dm, dd, dmag, ddmag, qm, rm, half;
    logic sa, sb, neg;
    n  = 8 << v.sz;
    m1 = (128'd1 << n) - 1;
    m2 = (n == 64) ? {128{1'b1}} : ((128'd1 << (2 * n)) - 1);
    hm = {64'd0, v.hi} & m1;
    lm = {64'd0, v.lo} & m1;
    dm = {64'd0, v.dv} & m1;
    dd = (hm << n) | lm;
    q = '0; r = '0; ov = 1'b0; dz = 1'b0; early = 1'b0;
    if (dm == 0) begin
      dz = 1'b1; early = 1'b1;
      return;
    end
    sa = v.sg & hm[n-1];
    sb = v.sg & dm[n-1];
    ddmag = sa ? (((~dd) + 1) & m2) : dd;
    dmag  = sb ? (((~dm) + 1) & m1) : dm;
    early = ((ddmag >> n) >= dmag);
    qm  = ddmag / dmag;
    rm  = ddmag % dmag;
    neg = sa ^ sb;
    half = 128'd1 << (n - 1);
    ov = early || (v.sg && (neg ? (qm > half) : (qm > half - 1)));
    q = 64'(neg ? (((~qm) + 1) & m1) : qm);
    r = 64'(sa  ? (((~rm) + 1) & m1) : rm);
  endfunction

  task automatic apply(input vec_t v);
    is_signed   = v.sg;
    size_sel    = v.sz;
    dividend_hi = v.hi;
    dividend_lo = v.lo;
    divisor     = v.dv;
  endtask

  task automatic do_vec(input vec_t v);
    logic [63:0] eq, er, m;
    logic eov, edz, eearly;
    int cyc, lat, n;
    string tag;
    ref_div(v, eq, er, eov, edz, eearly);
    n = 8 << v.sz;
    m = (n == 64) ? '1 : ((64'd1 << n) - 1);
    tag = v.sg ? "R3 R4" : "R2";
    if (((v.hi | v.lo | v.dv) & ~m) != 0) tag = "R10";
    @(negedge clk);
    apply(v);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    if (!eearly) chk("R5 busy after accept", 64'(busy), 64'd1);
    else         chk("R6 R7 no busy on early finish", 64'(busy), 64'd0);
    while (!done && cyc < 200) begin
      @(posedge clk); #1;
      cyc++;
    end
    lat = eearly ? 0 : (n / ((v.sz == 2'd0) ? 2 : 4)) + 1;
    chk("R5 latency", 64'(cyc), 64'(lat));
    chk("R6 div_zero", 64'(div_zero), 64'(edz));
    chk(v.sg ? "R8 overflow" : "R7 overflow", 64'(overflow), 64'(eov));
    if (!edz && !eov) begin
      chk({tag, " quotient"}, quotient, eq);
      chk({tag, " remainder"}, remainder, er);
    end
    chk("R9 busy low with done", 64'(busy), 64'd0);
    @(posedge clk); #1;
    chk("R9 done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] hq, hr, h;
    logic hov, hdz, hearly;
    int cyc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 div_zero", 64'(div_zero), 64'd0);
    chk("R1 overflow", 64'(overflow), 64'd0);
    chk("R1 quotient", quotient, 64'd0);
    chk("R1 remainder", remainder, 64'd0);

    for (int i = 0; i < NV; i++) do_vec(VECS[i]);

    // R9: start while busy is ignored
    ref_div(VECS[4], hq, hr, hov, hdz, hearly);
    @(negedge clk);
    apply(VECS[4]);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    repeat (3) begin
      @(posedge clk); #1;
      cyc++;
    end
    @(negedge clk);
    apply(VECS[0]);
    start = 1'b1;
    @(posedge clk); #1;
    cyc++;
    start = 1'b0;
    while (!done && cyc < 200) begin
      @(posedge clk); #1;
      cyc++;
    end
    chk("R9 restart ignored latency", 64'(cyc), 64'd17);
    chk("R9 restart ignored quotient", quotient, hq);
    chk("R9 restart ignored remainder", remainder, hr);
    h = quotient;
    repeat (4) @(posedge clk);
    #1;
    chk("R9 results hold", quotient, h);
    chk("R9 no spurious done", 64'(done), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule